// File: doc/BRIEF.md
# Posted-Write Watchdog Timer with Two-Word Enable Keys

This block is a watchdog timer. An up-counter runs toward its all-ones value at a rate taken from a slow (nominally 32 kHz) tick. The tick can be divided by a power-of-two prescaler. When the count wraps, the block raises a one-cycle reset request and reloads the counter from a programmable load value. Software services the watchdog by writing a trigger register with a value that differs from the last one written. Each service reloads the counter.

Every register write is posted. The write is captured at the bus edge and takes effect a fixed number of cycles later, which models the crossing into the timer domain. During that wait, the register's own pending bit is visible on `pend_o`. A write to a register whose pending bit is still set is dropped. The timer can be started or stopped only by a two-word key sequence written to the key register.

The key detector is a four-state machine:
- **STOPPED** moves to **START_ARMED** on 0xBBBB.
- **START_ARMED** moves to **RUNNING** on 0x4444 and falls back to STOPPED on any other word.
- **RUNNING** moves to **STOP_ARMED** on 0xAAAA.
- **STOP_ARMED** moves to STOPPED on 0x5555 and falls back to RUNNING on any other word.

Top module: `wdt_posted_key`

## Requirements
- R1: After reset, `pend_o` is 0, `count_o` is 0, `running_o` is 0 and `rst_req_o` is 0. The load value and the last trigger value are both 0, and the prescaler is disabled.
- R2: Registers are selected by `wr_sel_i`: 0 control, 1 load, 2 trigger, 3 key. A write sets pending bit `pend_o[wr_sel_i]` from the write edge. That bit clears on the edge SYNC_DLY (4) cycles later. The write takes effect on that same edge.
- R3: A write to a register whose pending bit is set is dropped. The earlier posted value takes effect unchanged.
- R4: A key word 0xBBBB applied in STOPPED, followed by the next applied key word 0x4444, sets `running_o` to 1. The first word alone leaves it at 0.
- R5: A key word 0xAAAA applied while running, followed by the next applied key word 0x5555, sets `running_o` to 0.
- R6: Out-of-order key words reset the detector:
  - In START_ARMED, any word other than 0x4444 returns to STOPPED.
  - In STOP_ARMED, any word other than 0x5555 returns to RUNNING.
  - A stop pair written while stopped has no effect.
  - A lone second word has no effect.
- R7: An applied trigger value reloads the counter from the load value only when it differs from the previously applied trigger value. An equal value leaves the count unchanged.
- R8: While running with the prescaler disabled, the count advances by 1 on every cycle with `tick_i` high. While stopped, ticks leave the count unchanged.
- R9: The control register uses bit 0 as prescaler enable and bits 3:1 as ratio r. When enabled, the count advances once every 2^r ticks. The tick phase restarts on a reload, on a control write taking effect, and while stopped.
- R10: When an advance finds the count at all ones, the counter reloads from the load value and `rst_req_o` is high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and timer logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse at the slow timer rate |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 load, 2 trigger, 3 key |
| wr_data_i | input | CNT_W | Write data |
| pend_o | output | 4 | Per-register write-pending flags, indexed by select |
| count_o | output | CNT_W | Current counter value |
| running_o | output | 1 | Timer enabled (RUNNING or STOP_ARMED) |
| rst_req_o | output | 1 | One-cycle reset request on wrap |

## Verification
A write strobed on edge E0 shows its pending bit after E0. The bit stays set through E3 and clears at E4. The write's effect also appears at E4: a new running state, a reload, a new load value or a new prescale.

A tick sampled on an edge changes `count_o` and `rst_req_o` on that same edge. The bench therefore drives every input on a falling edge and samples a falling edge later. It checks the pending bits both immediately after the write and three cycles later. Register effects are checked only after four falling edges have passed.

// File: rtl/wdt_posted_pkg.sv
`timescale 1ns/1ps
package wdt_posted_pkg;

    localparam int NUM_REGS = 4;

    // register select codes; the pending bit index equals the select code
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LOAD = 2'd1,
        SEL_TRIG = 2'd2,
        SEL_KEY  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        KS_STOPPED     = 2'd0,
        KS_START_ARMED = 2'd1,
        KS_RUNNING     = 2'd2,
        KS_STOP_ARMED  = 2'd3
    } key_state_e;

    localparam logic [15:0] KEY_START_A = 16'hBBBB;
    localparam logic [15:0] KEY_START_B = 16'h4444;
    localparam logic [15:0] KEY_STOP_A  = 16'hAAAA;
    localparam logic [15:0] KEY_STOP_B  = 16'h5555;

endpackage

// File: rtl/wdt_post_slot.sv
`timescale 1ns/1ps
// One posted-write slot: captures a write, holds it pending for SYNC_DLY
// cycles, then presents it for one cycle on fire_o.
module wdt_post_slot #(
    parameter int DATA_W   = 16,
    parameter int SYNC_DLY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              pend_o,
    output logic              fire_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int CW = (SYNC_DLY < 2) ? 1 : $clog2(SYNC_DLY);

    logic          pend_q;
    logic [CW-1:0] wait_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            wait_q <= '0;
            data_q <= '0;
        end else if (pend_q) begin
            if (wait_q == '0) begin
                pend_q <= 1'b0;
            end else begin
                wait_q <= wait_q - 1'b1;
            end
        end else if (wr_hit_i) begin
            pend_q <= 1'b1;
            wait_q <= CW'(SYNC_DLY - 1);
            data_q <= wr_data_i;
        end
    end

    assign pend_o = pend_q;
    assign fire_o = pend_q && (wait_q == '0);
    assign data_o = data_q;

endmodule

// File: rtl/wdt_key_fsm.sv
`timescale 1ns/1ps
// Two-word key sequence detector holding the run/stop state.
module wdt_key_fsm
    import wdt_posted_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_fire_i,
    input  logic [DATA_W-1:0] key_word_i,
    output logic              running_o
);
    key_state_e state_q, state_d;

    logic is_start_a, is_start_b, is_stop_a, is_stop_b;
    assign is_start_a = (key_word_i == DATA_W'(KEY_START_A));
    assign is_start_b = (key_word_i == DATA_W'(KEY_START_B));
    assign is_stop_a  = (key_word_i == DATA_W'(KEY_STOP_A));
    assign is_stop_b  = (key_word_i == DATA_W'(KEY_STOP_B));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KS_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (key_fire_i) begin
            unique case (state_q)
                KS_STOPPED:     state_d = is_start_a ? KS_START_ARMED : KS_STOPPED;
                KS_START_ARMED: state_d = is_start_b ? KS_RUNNING     : KS_STOPPED;
                KS_RUNNING:     state_d = is_stop_a  ? KS_STOP_ARMED  : KS_RUNNING;
                KS_STOP_ARMED:  state_d = is_stop_b  ? KS_STOPPED     : KS_RUNNING;
                default:        state_d = KS_STOPPED;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            KS_RUNNING, KS_STOP_ARMED: running_o = 1'b1;
            default:                   running_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
// Power-of-two tick divider producing one advance strobe per 2^ratio ticks.
module wdt_prescaler #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               run_i,
    input  logic               clear_i,
    input  logic               pre_en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               step_o
);
    localparam int PC_W = (1 << RATIO_W) - 1;

    logic [PC_W-1:0] phase_q;
    logic [PC_W-1:0] term;

    assign term   = PC_W'((32'd1 << ratio_i) - 32'd1);
    assign step_o = run_i && tick_i && (!pre_en_i || (phase_q == term));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear_i || !run_i || !pre_en_i) begin
            phase_q <= '0;
        end else if (tick_i) begin
            phase_q <= (phase_q == term) ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_posted_key.sv
`timescale 1ns/1ps
module wdt_posted_key
    import wdt_posted_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SYNC_DLY = 4,
    parameter int RATIO_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [3:0]       pend_o,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             rst_req_o
);
    localparam int CFG_W = RATIO_W + 1;

    logic [NUM_REGS-1:0] slot_pend;
    logic [NUM_REGS-1:0] slot_fire;
    logic [CNT_W-1:0]    slot_data [1:NUM_REGS-1];
    logic [CFG_W-1:0]    cfg_data;

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_slot
            logic hit;
            assign hit = wr_en_i && (wr_sel_i == 2'(g));
            if (g == int'(SEL_CTRL)) begin : g_cfg
                wdt_post_slot #(.DATA_W(CFG_W), .SYNC_DLY(SYNC_DLY)) u_slot (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .wr_hit_i (hit),
                    .wr_data_i(wr_data_i[CFG_W-1:0]),
                    .pend_o   (slot_pend[g]),
                    .fire_o   (slot_fire[g]),
                    .data_o   (cfg_data)
                );
            end else begin : g_word
                wdt_post_slot #(.DATA_W(CNT_W), .SYNC_DLY(SYNC_DLY)) u_slot (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .wr_hit_i (hit),
                    .wr_data_i(wr_data_i),
                    .pend_o   (slot_pend[g]),
                    .fire_o   (slot_fire[g]),
                    .data_o   (slot_data[g])
                );
            end
        end
    endgenerate

    // effective (timer-domain) register state
    logic [CFG_W-1:0] cfg_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] trig_last_q;

    logic             reload;
    logic             key_fire;
    logic [CNT_W-1:0] key_word;
    logic             running;
    logic             step;

    assign reload   = slot_fire[SEL_TRIG] && (slot_data[SEL_TRIG] != trig_last_q);
    assign key_fire = slot_fire[SEL_KEY];
    assign key_word = slot_data[SEL_KEY];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            load_q      <= '0;
            trig_last_q <= '0;
        end else begin
            if (slot_fire[SEL_CTRL]) cfg_q       <= cfg_data;
            if (slot_fire[SEL_LOAD]) load_q      <= slot_data[SEL_LOAD];
            if (slot_fire[SEL_TRIG]) trig_last_q <= slot_data[SEL_TRIG];
        end
    end

    wdt_key_fsm #(.DATA_W(CNT_W)) u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_fire_i(key_fire),
        .key_word_i(key_word),
        .running_o (running)
    );

    wdt_prescaler #(.RATIO_W(RATIO_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .run_i   (running),
        .clear_i (reload || slot_fire[SEL_CTRL]),
        .pre_en_i(cfg_q[0]),
        .ratio_i (cfg_q[CFG_W-1:1]),
        .step_o  (step)
    );

    logic [CNT_W-1:0] count_q;
    logic             rst_req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= 1'b0;
            if (reload) begin
                count_q <= load_q;
            end else if (step) begin
                if (count_q == '1) begin
                    count_q   <= load_q;
                    rst_req_q <= 1'b1;
                end else begin
                    count_q <= count_q + 1'b1;
                end
            end
        end
    end

    assign pend_o    = slot_pend;
    assign count_o   = count_q;
    assign running_o = running;
    assign rst_req_o = rst_req_q;

endmodule

// File: rtl/wdt_posted_key_chk.sv
`timescale 1ns/1ps
module wdt_posted_key_chk #(
    parameter int CNT_W    = 16,
    parameter int SYNC_DLY = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic [3:0]       pend_o,
    input logic [CNT_W-1:0] count_o,
    input logic             running_o,
    input logic             rst_req_o,
    input logic             reload,
    input logic             key_fire,
    input logic [CNT_W-1:0] key_word
);
    int unsigned hi_cnt [4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) hi_cnt[i] <= 0;
        end else begin
            for (int i = 0; i < 4; i++) hi_cnt[i] <= pend_o[i] ? hi_cnt[i] + 1 : 0;
        end
    end

    // R2
    pend_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt[0] <= SYNC_DLY) && (hi_cnt[1] <= SYNC_DLY) &&
        (hi_cnt[2] <= SYNC_DLY) && (hi_cnt[3] <= SYNC_DLY));

    // R2
    pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & ~$past(pend_o)) != 4'b0) |-> $past(wr_en_i));

    // R4
    start_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_o) |-> ($past(key_fire) && $past(key_word) == CNT_W'(16'h4444)));

    // R5
    stop_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> ($past(key_fire) && $past(key_word) == CNT_W'(16'h5555)));

    // R8
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(running_o) && !$past(reload)) |-> $stable(count_o));

    // R10
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> ($past(count_o) == '1 && $past(running_o)));

endmodule

bind wdt_posted_key wdt_posted_key_chk #(.CNT_W(CNT_W), .SYNC_DLY(SYNC_DLY)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .pend_o   (pend_o),
    .count_o  (count_o),
    .running_o(running_o),
    .rst_req_o(rst_req_o),
    .reload   (reload),
    .key_fire (key_fire),
    .key_word (key_word)
);

// File: tb/wdt_posted_key_test.sv
`timescale 1ns/1ps
module wdt_posted_key_test;
    localparam int CNT_W = 16;
    localparam int DLY   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_i = 1'b0;
    logic             wr_en_i = 1'b0;
    logic [1:0]       wr_sel_i = 2'd0;
    logic [CNT_W-1:0] wr_data_i = '0;
    logic [3:0]       pend_o;
    logic [CNT_W-1:0] count_o;
    logic             running_o;
    logic             rst_req_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    wdt_posted_key #(.CNT_W(CNT_W), .SYNC_DLY(DLY), .RATIO_W(3)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .wr_en_i  (wr_en_i),
        .wr_sel_i (wr_sel_i),
        .wr_data_i(wr_data_i),
        .pend_o   (pend_o),
        .count_o  (count_o),
        .running_o(running_o),
        .rst_req_o(rst_req_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // strobe one write; returns at the falling edge after the write edge
    task automatic wr(input logic [1:0] sel, input logic [CNT_W-1:0] data);
        wr_en_i   = 1'b1;
        wr_sel_i  = sel;
        wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic settle();
        repeat (DLY) @(negedge clk);
    endtask

    task automatic wr_done(input logic [1:0] sel, input logic [CNT_W-1:0] data);
        wr(sel, data);
        settle();
    endtask

    task automatic tick();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pend", 32'(pend_o), 32'h0);
        check("R1 count", 32'(count_o), 32'h0);
        check("R1 running", 32'(running_o), 32'h0);
        check("R1 rst_req", 32'(rst_req_o), 32'h0);
    endtask

    task automatic t_posted();
        wr(2'd1, 16'h0100);
        check("R2 load pend set", 32'(pend_o), 32'h2);
        repeat (DLY - 1) @(negedge clk);
        check("R2 load pend held", 32'(pend_o), 32'h2);
        @(negedge clk);
        check("R2 load pend clear", 32'(pend_o), 32'h0);
        wr(2'd2, 16'h0001);
        check("R2 trig pend set", 32'(pend_o), 32'h4);
        repeat (DLY - 1) @(negedge clk);
        check("R2 no reload before apply", 32'(count_o), 32'h0);
        @(negedge clk);
        check("R7 reload on new trigger", 32'(count_o), 32'h0100);
    endtask

    task automatic t_drop();
        wr(2'd1, 16'h0200);
        wr(2'd1, 16'h0300);
        settle();
        wr_done(2'd2, 16'h0002);
        check("R3 dropped load write", 32'(count_o), 32'h0200);
    endtask

    task automatic t_start_bad();
        wr_done(2'd3, 16'hBBBB);
        wr_done(2'd3, 16'h1234);
        wr_done(2'd3, 16'h4444);
        check("R6 broken start sequence", 32'(running_o), 32'h0);
        wr_done(2'd3, 16'hAAAA);
        wr_done(2'd3, 16'h5555);
        check("R6 stop pair while stopped", 32'(running_o), 32'h0);
        tick();
        tick();
        check("R8 stopped holds count", 32'(count_o), 32'h0200);
    endtask

    task automatic t_start();
        wr(2'd3, 16'hBBBB);
        check("R2 key pend set", 32'(pend_o), 32'h8);
        settle();
        check("R4 first word alone", 32'(running_o), 32'h0);
        wr(2'd3, 16'h4444);
        repeat (DLY - 1) @(negedge clk);
        check("R4 not yet running", 32'(running_o), 32'h0);
        @(negedge clk);
        check("R4 running after key pair", 32'(running_o), 32'h1);
    endtask

    task automatic t_count();
        tick();
        check("R8 first tick", 32'(count_o), 32'h0201);
        tick();
        tick();
        check("R8 three ticks", 32'(count_o), 32'h0203);
        @(negedge clk);
        check("R8 no tick no change", 32'(count_o), 32'h0203);
    endtask

    task automatic t_trig_same();
        wr_done(2'd2, 16'h0002);
        check("R7 equal trigger no reload", 32'(count_o), 32'h0203);
        wr_done(2'd2, 16'h0005);
        check("R7 differing trigger reloads", 32'(count_o), 32'h0200);
    endtask

    task automatic t_prescale();
        wr_done(2'd0, 16'h0005);
        wr_done(2'd2, 16'h0006);
        check("R9 reload before prescale", 32'(count_o), 32'h0200);
        tick();
        tick();
        tick();
        check("R9 three of four ticks", 32'(count_o), 32'h0200);
        tick();
        check("R9 fourth tick steps", 32'(count_o), 32'h0201);
        tick();
        tick();
        tick();
        tick();
        check("R9 second period", 32'(count_o), 32'h0202);
        wr_done(2'd0, 16'h0000);
        tick();
        check("R9 prescaler off", 32'(count_o), 32'h0203);
    endtask

    task automatic t_overflow();
        wr_done(2'd1, 16'hFFFD);
        wr_done(2'd2, 16'h0007);
        check("R7 reload to new load", 32'(count_o), 32'hFFFD);
        tick();
        tick();
        check("R10 at all ones", 32'(count_o), 32'hFFFF);
        check("R10 no request yet", 32'(rst_req_o), 32'h0);
        tick();
        check("R10 wrap reloads", 32'(count_o), 32'hFFFD);
        check("R10 request raised", 32'(rst_req_o), 32'h1);
        @(negedge clk);
        check("R10 request one cycle", 32'(rst_req_o), 32'h0);
    endtask

    task automatic t_stop();
        wr_done(2'd3, 16'hAAAA);
        wr_done(2'd3, 16'h0000);
        check("R6 broken stop sequence", 32'(running_o), 32'h1);
        wr_done(2'd3, 16'h5555);
        check("R6 lone stop word", 32'(running_o), 32'h1);
        wr_done(2'd3, 16'hAAAA);
        check("R5 still running after first", 32'(running_o), 32'h1);
        wr_done(2'd3, 16'h5555);
        check("R5 stopped", 32'(running_o), 32'h0);
        tick();
        check("R5 count frozen", 32'(count_o), 32'hFFFD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_posted();
        t_drop();
        t_start_bad();
        t_start();
        t_count();
        t_trig_same();
        t_prescale();
        t_overflow();
        t_stop();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule